// File: doc/BRIEF.md
# Cartridge Banking Control Registers

This block holds the control state of an 8-bit home-computer expansion cartridge. It has two bus-mapped registers inside the IO1 page. A primary register drives the two memory-configuration lines, picks ROM or RAM, carries three bank-address bits and a kill switch. An extended register enables the accessory connector, carries the RAM-banking permission, the freeze-disable option, the alternate I/O map used alongside a RAM expansion unit, and a fourth bank-address bit that only exists while the flash jumper is fitted. Both addresses return the same status byte when read.

Writes take effect on the rising clock edge where the IO1 select is high, read/write is low and the low address byte matches one of the two registers. The bank bits A13, A14 and A15 live in one shared copy, and either register can write them. The freeze sequencer outside this block reports an active freeze as an input flag. While that flag is high, this block shields the memory-configuration lines from software. A primary write with the release bit set lifts that shield and signals the sequencer for one cycle.

Top module: `cart_regs`

## Requirements
- R1: A synchronous reset with `rst_n` low clears every held bit. The one exception is the EXROM-release bit, which takes the value of `flash_jumper`: the primary register reads as 0x02 with the jumper fitted and 0x00 without it. `armed` is set, so the first extended write is accepted.
- R2: Primary write decoding:
  - bit 0 = 1 asserts GAME (`game_on`).
  - bit 1 = 1 releases EXROM (`exrom_on` low).
  - bit 5 = 1 selects RAM.
  - bits 3, 4 and 7 load A13, A14 and A15 (`bank_addr[0]`, `[1]`, `[2]`).
- R3: A primary write with bit 2 = 1 kills the cartridge. From then until reset:
  - `cart_off` is 1 and `game_on` and `exrom_on` are 0.
  - Every write to either register is ignored.
  - `rdata_oe` stays 0 and `rdata` reads 0.
- R4: Extended write decoding:
  - bit 0 sets accessory enable.
  - bits 3, 4 and 7 load the same shared A13, A14 and A15 as the primary register.
  - bit 1 is AllowBank, bit 2 is NoFreeze and bit 6 is the alternate map.
  - bit 5 loads A16 (`bank_addr[3]`).
- R5: Without the flash jumper:
  - extended bits 1, 2 and 6 are accepted only on the first extended write after reset or re-arm.
  - A16 is forced to 0 on every extended write.
- R6: With the flash jumper fitted:
  - every extended write updates bits 1 and 2.
  - the alternate-map bit can be cleared but never set.
  - no write consumes the one-time permission.
- R7: Fitting the flash jumper for at least one clock and then removing it allows exactly one more write of extended bits 1, 2 and 6.
- R8: Reading either address gives the same byte:
  - bit 0 = flash jumper, bit 1 = AllowBank, bit 2 = live freeze-button level.
  - bits 3, 4, 5 and 7 = A13, A14, A16 and A15.
  - bit 6 = alternate map.
  - `rdata_oe` is high during such a read.
- R9: While `freeze_active` is high, a primary write with bit 6 = 0 leaves GAME and EXROM unchanged but updates the other fields. A primary write with bit 6 = 1 applies bits 0 and 1 and pulses `freeze_release` for exactly the following cycle. With `freeze_active` low, bit 6 has no effect.
- R10: A cycle that fails to select a register changes no state. This covers select low, read/write high, or a low address byte other than 0x00 (primary) or 0x01 (extended).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io1_sel | input | 1 | IO1 page select |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr_lo | input | 8 | Low address byte within IO1 |
| wdata | input | 8 | Write data |
| flash_jumper | input | 1 | Flash-mode jumper level, synchronous |
| freeze_button | input | 1 | Live freeze-button level, synchronous |
| freeze_active | input | 1 | Freeze map in force, from the sequencer |
| rdata | output | 8 | Status byte, 0 when not driven |
| rdata_oe | output | 1 | Read data valid |
| game_on | output | 1 | GAME line asserted |
| exrom_on | output | 1 | EXROM line asserted |
| cart_off | output | 1 | Cartridge killed |
| ram_sel | output | 1 | 1 = RAM, 0 = ROM |
| bank_addr | output | 4 | A13, A14, A15, A16 in bits 0 to 3 |
| acc_en | output | 1 | Accessory connector enabled |
| allow_bank | output | 1 | RAM banking allowed in the I/O window |
| no_freeze | output | 1 | Freeze function disabled |
| reu_map | output | 1 | Alternate I/O map active |
| freeze_release | output | 1 | One-cycle end-of-freeze request |

## Verification
The assertions assume that `flash_jumper`, `freeze_button` and `freeze_active` are already synchronous to `clk` and change only between edges. They also assume that the external sequencer alone drops `freeze_active`. The bench drives every input on the falling edge and moves the jumper and freeze flag only while the bus is idle. It holds the jumper for at least two clocks so that a re-arm is always seen. It never lowers `freeze_active` in the cycle of a release write, so a gated write and its release are never mixed.

// File: rtl/cart_regs_pkg.sv
// Shared bit positions and types for the cartridge control registers.
// Assumes an 8-bit data bus; positions are fixed by software convention.
package cart_regs_pkg;
    localparam int DATA_W = 8;
    localparam int BANK_W = 4;

    // primary register fields
    localparam int P_GAME  = 0;
    localparam int P_EXROM = 1;
    localparam int P_KILL  = 2;
    localparam int P_A13   = 3;
    localparam int P_A14   = 4;
    localparam int P_RAM   = 5;
    localparam int P_UNFRZ = 6;
    localparam int P_A15   = 7;

    // extended register fields (A13/A14/A15 share the primary positions)
    localparam int X_ACC   = 0;
    localparam int X_ALLOW = 1;
    localparam int X_NOFRZ = 2;
    localparam int X_A16   = 5;
    localparam int X_REU   = 6;

    typedef struct packed {
        logic acc;
        logic allow;
        logic nofrz;
        logic reu;
    } cart_opt_t;
endpackage

// File: rtl/cart_wr_decode.sv
// Bus decoder: turns select, direction and low address into write and read
// strobes for the two registers. Assumes all inputs are synchronous.
// Once the cartridge is killed no strobe is produced.
module cart_wr_decode #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PRI_ADDR = '0,
    parameter logic [ADDR_W-1:0] EXT_ADDR = 1
) (
    input  logic              io1_sel,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic              killed,
    output logic              wr_pri,
    output logic              wr_ext,
    output logic              rd_hit
);
    logic hit_pri, hit_ext;

    // address match and strobe generation
    always_comb begin
        hit_pri = io1_sel && (addr_lo == PRI_ADDR);
        hit_ext = io1_sel && (addr_lo == EXT_ADDR);
        wr_pri  = hit_pri && !rw_n && !killed;
        wr_ext  = hit_ext && !rw_n && !killed;
        rd_hit  = (hit_pri || hit_ext) && rw_n && !killed;
    end
endmodule

// File: rtl/cart_opt_lock.sv
// One-time write permission for the protected extended bits.
// Armed by reset and by any clock with the flash jumper fitted; consumed by
// the first extended write made with the jumper removed.
module cart_opt_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic flash_jumper,
    input  logic wr_ext,
    output logic armed
);
    // permission flag update
    always_ff @(posedge clk) begin
        if (!rst_n)            armed <= 1'b1;
        else if (flash_jumper) armed <= 1'b1;
        else if (wr_ext)       armed <= 1'b0;
    end

    // removing the jumper must leave one write available (R7)
    p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_jumper) |-> armed);
endmodule

// File: rtl/cart_status_mux.sv
// Builds the status byte returned at both register addresses and gates it
// with the read strobe. Purely combinational.
module cart_status_mux
    import cart_regs_pkg::*;
(
    input  logic              rd_hit,
    input  logic              flash_jumper,
    input  logic              freeze_button,
    input  logic [BANK_W-1:0] bank,
    input  cart_opt_t         opt,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    logic [DATA_W-1:0] status;

    // assemble status fields
    always_comb begin
        status          = '0;
        status[0]       = flash_jumper;
        status[X_ALLOW] = opt.allow;
        status[2]       = freeze_button;
        status[P_A13]   = bank[0];
        status[P_A14]   = bank[1];
        status[X_A16]   = bank[3];
        status[X_REU]   = opt.reu;
        status[P_A15]   = bank[2];
        rdata_oe        = rd_hit;
        rdata           = rd_hit ? status : '0;
    end
endmodule

// File: rtl/cart_regs.sv
// Cartridge control register pair: primary (memory lines, bank, ROM/RAM,
// kill, freeze release) and extended (options, A16). Assumes jumper, button
// and freeze flag are synchronous to clk; freeze sequencing lives outside.
module cart_regs
    import cart_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PRI_ADDR = '0,
    parameter logic [ADDR_W-1:0] EXT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io1_sel,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flash_jumper,
    input  logic              freeze_button,
    input  logic              freeze_active,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              game_on,
    output logic              exrom_on,
    output logic              cart_off,
    output logic              ram_sel,
    output logic [BANK_W-1:0] bank_addr,
    output logic              acc_en,
    output logic              allow_bank,
    output logic              no_freeze,
    output logic              reu_map,
    output logic              freeze_release
);
    logic              wr_pri, wr_ext, rd_hit, armed;
    logic              game_q, exrom_n_q, killed_q, ram_q, rel_q;
    logic [BANK_W-1:0] bank_q;
    cart_opt_t         opt_q;
    logic              prot_ok;

    cart_wr_decode #(
        .ADDR_W(ADDR_W), .PRI_ADDR(PRI_ADDR), .EXT_ADDR(EXT_ADDR)
    ) u_dec (
        .io1_sel(io1_sel), .rw_n(rw_n), .addr_lo(addr_lo),
        .killed(killed_q), .wr_pri(wr_pri), .wr_ext(wr_ext), .rd_hit(rd_hit)
    );

    cart_opt_lock u_lock (
        .clk(clk), .rst_n(rst_n), .flash_jumper(flash_jumper),
        .wr_ext(wr_ext), .armed(armed)
    );

    cart_status_mux u_stat (
        .rd_hit(rd_hit), .flash_jumper(flash_jumper),
        .freeze_button(freeze_button), .bank(bank_q), .opt(opt_q),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // protected extended bits may be written in flash mode or when armed
    always_comb prot_ok = flash_jumper || armed;

    // register state update for both addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            game_q    <= 1'b0;
            exrom_n_q <= flash_jumper;
            killed_q  <= 1'b0;
            ram_q     <= 1'b0;
            bank_q    <= '0;
            opt_q     <= '0;
            rel_q     <= 1'b0;
        end else begin
            rel_q <= 1'b0;
            if (wr_pri) begin
                killed_q  <= wdata[P_KILL];
                ram_q     <= wdata[P_RAM];
                bank_q[0] <= wdata[P_A13];
                bank_q[1] <= wdata[P_A14];
                bank_q[2] <= wdata[P_A15];
                if (!freeze_active || wdata[P_UNFRZ]) begin
                    game_q    <= wdata[P_GAME];
                    exrom_n_q <= wdata[P_EXROM];
                end
                rel_q <= freeze_active && wdata[P_UNFRZ];
            end
            if (wr_ext) begin
                opt_q.acc <= wdata[X_ACC];
                bank_q[0] <= wdata[P_A13];
                bank_q[1] <= wdata[P_A14];
                bank_q[2] <= wdata[P_A15];
                bank_q[3] <= flash_jumper && wdata[X_A16];
                if (prot_ok) begin
                    opt_q.allow <= wdata[X_ALLOW];
                    opt_q.nofrz <= wdata[X_NOFRZ];
                end
                if (flash_jumper)  opt_q.reu <= opt_q.reu && wdata[X_REU];
                else if (armed)    opt_q.reu <= wdata[X_REU];
            end
        end
    end

    // drive the cartridge lines and option outputs
    always_comb begin
        game_on        = game_q && !killed_q;
        exrom_on       = !exrom_n_q && !killed_q;
        cart_off       = killed_q;
        ram_sel        = ram_q;
        bank_addr      = bank_q;
        acc_en         = opt_q.acc;
        allow_bank     = opt_q.allow;
        no_freeze      = opt_q.nofrz;
        reu_map        = opt_q.reu;
        freeze_release = rel_q;
    end

    p_kill_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        killed_q |=> killed_q && $stable(bank_q) && $stable(game_q) && $stable(opt_q));
    p_lock_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ext && !flash_jumper && !armed) |=>
            $stable(opt_q.allow) && $stable(opt_q.nofrz) && $stable(opt_q.reu));
    p_a16_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ext && !flash_jumper) |=> !bank_q[3]);
    p_flash_noreu_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ext && flash_jumper && !opt_q.reu) |=> !opt_q.reu);
    p_freeze_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pri && freeze_active && !wdata[P_UNFRZ]) |=>
            $stable(game_q) && $stable(exrom_n_q));
    p_release_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_release |-> $past(wr_pri) && $past(freeze_active));
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!io1_sel || rw_n) |=> $stable(bank_q) && $stable(opt_q) && $stable(ram_q));
endmodule

// File: tb/cart_regs_test.sv
// Self-checking bench: sweeps both registers across all byte values in
// each mode and compares against an arithmetic model of the requirements.
module cart_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io1_sel = 1'b0, rw_n = 1'b1;
    logic [7:0] addr_lo = '0, wdata = '0;
    logic       flash_jumper = 1'b0, freeze_button = 1'b0, freeze_active = 1'b0;
    logic [7:0] rdata;
    logic       rdata_oe, game_on, exrom_on, cart_off, ram_sel;
    logic [3:0] bank_addr;
    logic       acc_en, allow_bank, no_freeze, reu_map, freeze_release;

    int total = 0, bad = 0;

    // model state
    logic mg, mx, mk, mr, ma, mal, mn, mu, marm;
    logic [3:0] mb;

    cart_regs uut (
        .clk(clk), .rst_n(rst_n), .io1_sel(io1_sel), .rw_n(rw_n),
        .addr_lo(addr_lo), .wdata(wdata), .flash_jumper(flash_jumper),
        .freeze_button(freeze_button), .freeze_active(freeze_active),
        .rdata(rdata), .rdata_oe(rdata_oe), .game_on(game_on),
        .exrom_on(exrom_on), .cart_off(cart_off), .ram_sel(ram_sel),
        .bank_addr(bank_addr), .acc_en(acc_en), .allow_bank(allow_bank),
        .no_freeze(no_freeze), .reu_map(reu_map), .freeze_release(freeze_release)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog: run did not complete, got hung exp done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic check_state(input string req);
        check(req, {game_on, exrom_on, cart_off, ram_sel, bank_addr, acc_en,
                    allow_bank, no_freeze, reu_map},
              {mg & ~mk, ~mx & ~mk, mk, mr, mb, ma, mal, mn, mu});
    endtask

    task automatic do_reset(input logic fj);
        @(negedge clk);
        flash_jumper = fj; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mg = 0; mx = fj; mk = 0; mr = 0; mb = '0; ma = 0; mal = 0; mn = 0; mu = 0;
        marm = 1;
    endtask

    task automatic set_jumper(input logic fj);
        @(negedge clk);
        flash_jumper = fj;
        repeat (2) @(negedge clk);
        if (fj) marm = 1;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] v,
                          input logic sel, input logic rwv);
        @(negedge clk);
        io1_sel = sel; rw_n = rwv; addr_lo = a; wdata = v;
        @(negedge clk);
        io1_sel = 1'b0; rw_n = 1'b1;
        if (sel && !rwv && !mk) begin
            if (a == 8'h00) begin
                mk = v[2]; mr = v[5]; mb[0] = v[3]; mb[1] = v[4]; mb[2] = v[7];
                if (!freeze_active || v[6]) begin mg = v[0]; mx = v[1]; end
            end else if (a == 8'h01) begin
                ma = v[0]; mb[0] = v[3]; mb[1] = v[4]; mb[2] = v[7];
                mb[3] = flash_jumper ? v[5] : 1'b0;
                if (flash_jumper || marm) begin mal = v[1]; mn = v[2]; end
                if (flash_jumper) mu = mu & v[6];
                else if (marm) mu = v[6];
                if (!flash_jumper) marm = 0;
            end
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input string req);
        @(negedge clk);
        io1_sel = 1'b1; rw_n = 1'b1; addr_lo = a;
        #1;
        check(req, {23'd0, rdata_oe, rdata},
              mk ? 32'd0 : {23'd0, 1'b1, mb[2], mu, mb[3], mb[1], mb[0],
                            freeze_button, mal, flash_jumper});
        io1_sel = 1'b0;
    endtask

    initial begin
        // R1: reset without jumper, then with jumper
        do_reset(1'b0);
        check_state("R1");
        rd_chk(8'h00, "R1");
        do_reset(1'b1);
        check_state("R1");
        rd_chk(8'h01, "R1");
        do_reset(1'b0);

        // R2, R8, R9: primary sweep without kill, no freeze (bit6 inert)
        for (int v = 0; v < 256; v++) begin
            if (v[2]) continue;
            bus_wr(8'h00, v[7:0], 1'b1, 1'b0);
            check("R9", {31'd0, freeze_release}, 32'd0);
            check_state("R2");
            rd_chk(v[0] ? 8'h00 : 8'h01, "R8");
        end

        // R10: non-selecting cycles
        bus_wr(8'h00, 8'hB9, 1'b1, 1'b0);
        check_state("R10");
        bus_wr(8'h00, 8'h42, 1'b0, 1'b0); check_state("R10");
        bus_wr(8'h01, 8'h42, 1'b1, 1'b1); check_state("R10");
        bus_wr(8'h05, 8'h42, 1'b1, 1'b0); check_state("R10");

        // R4, R5: first extended write accepted, later protected bits held
        bus_wr(8'h01, 8'h47, 1'b1, 1'b0);
        check_state("R4");
        for (int v = 0; v < 256; v++) begin
            bus_wr(8'h01, v[7:0], 1'b1, 1'b0);
            check_state("R5");
        end
        freeze_button = 1'b1;
        rd_chk(8'h00, "R8");
        freeze_button = 1'b0;
        rd_chk(8'h01, "R8");

        // R6: flash mode, reu may clear but not set, A16 writable
        set_jumper(1'b1);
        for (int v = 0; v < 256; v++) begin
            bus_wr(8'h01, v[7:0], 1'b1, 1'b0);
            check_state("R6");
            rd_chk(8'h01, "R8");
        end

        // R7: removing the jumper allows exactly one more protected write
        set_jumper(1'b0);
        bus_wr(8'h01, 8'h46, 1'b1, 1'b0); check_state("R7");
        bus_wr(8'h01, 8'h00, 1'b1, 1'b0); check_state("R7");
        check("R7", {29'd0, allow_bank, no_freeze, reu_map}, 32'd7);

        // R9: freeze gating and release pulse
        @(negedge clk); freeze_active = 1'b1;
        for (int v = 0; v < 256; v++) begin
            if (v[2] || v[6]) continue;
            bus_wr(8'h00, v[7:0], 1'b1, 1'b0);
            check_state("R9");
        end
        bus_wr(8'h00, 8'h41, 1'b1, 1'b0);
        check("R9", {31'd0, freeze_release}, 32'd1);
        check_state("R9");
        @(negedge clk);
        check("R9", {31'd0, freeze_release}, 32'd0);
        freeze_active = 1'b0;

        // R3: kill, then every write ignored and reads undriven
        bus_wr(8'h00, 8'h8D, 1'b1, 1'b0);
        check_state("R3");
        bus_wr(8'h00, 8'h01, 1'b1, 1'b0); check_state("R3");
        bus_wr(8'h01, 8'hFF, 1'b1, 1'b0); check_state("R3");
        rd_chk(8'h00, "R3");
        do_reset(1'b0);
        check_state("R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule